// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold Interrupts

This block sits between a processor-side register port and a serial bus engine. It holds one byte queue for outgoing data and one for incoming data. Software fills the transmit queue and drains the receive queue through word-addressed register accesses. The engine takes bytes from the transmit queue and delivers bytes into the receive queue through single-cycle pop and push strobes.

Seven status conditions are collected into a status word. Two are level thresholds: transmit running low and receive filling up. Four are error flags: overrun and underrun on each queue. The last is a receive idle timer, which fires when a partial batch of received bytes has been left sitting without new arrivals. Status bits are cleared by writing ones. A registered interrupt line reports any status bit whose enable bit is set. Bus timing and protocol sequencing stay in the engine.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: Word 0 is the queue control word and reads back as written. Bit 0 enables the receive queue and bit 1 enables the transmit queue. Bits 10:4 hold the receive trigger and bits 22:16 hold the transmit trigger. All other bits read 0, and the word resets to 0.
- R2: A disabled queue is emptied at the next clock and holds level 0. It ignores pushes and pops and raises no flag for them.
- R3: Writing word 5 pushes reg_wdata_i[7:0] into the transmit queue. tx_data_o shows the oldest byte, or 0 when the queue is empty. tx_pop_i removes that byte. Bytes leave in the order they were written.
- R4: Reading word 6 returns the oldest receive byte in reg_rdata_o[7:0] in the same cycle and removes it at the clock edge. rx_push_i with rx_data_i appends a byte.
- R5: Word 4 is the queue status word. The transmit level is in bits 6:0, transmit full at bit 7 and transmit empty at bit 8. The receive level is in bits 22:16, receive full at bit 23 and receive empty at bit 24.
- R6: A push into a full queue drops the byte. It sets status bit 3 for transmit or bit 5 for receive. Fullness is judged before any pop in the same cycle, and that pop still completes.
- R7: A pop from an empty queue returns 0. It sets status bit 2 for transmit or bit 4 for receive. Emptiness is judged before any push in the same cycle, and that push still completes.
- R8: Status bit 0 is set on every clock while the transmit queue is enabled and its level is at or below the transmit trigger. Status bit 1 is set on every clock while the receive queue is enabled and its level is at or above the receive trigger.
- R9: Status bit 6 is set once the following has held for N+1 consecutive cycles: the receive queue is enabled, its level is above 0 and below the receive trigger, and no byte is pushed. N is word 1 bits 3:0. The bit is set again on every further such cycle.
- R10: Word 3 is the status word. Writing 1 to a bit clears it and writing 0 leaves it unchanged. A bit whose set condition holds in the same cycle stays set. The word resets to 0.
- R11: irq_o is registered. It goes high one cycle after any status bit is 1 while the same bit of word 2 (enable mask, bits 6:0) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, same cycle |
| tx_pop_i | input | 1 | Engine takes the head transmit byte |
| tx_data_o | output | 8 | Head transmit byte |
| rx_push_i | input | 1 | Engine delivers a receive byte |
| rx_data_i | input | 8 | Receive byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with a queue depth of 4 instead of 16. Both queues can then be filled to full and beyond within a few cycles, so overrun with a same-cycle pop, underrun with a same-cycle push, full and empty flags, and triggers at and beyond the depth are all reached. A trail count of 3 keeps the receive idle window short. The window stays long enough to show that a push restarts the timer and that a write-one clear loses to a condition that is still active.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int unsigned LVL_FW  = 7;   // level / trigger field width
  localparam int unsigned STAT_W  = 7;
  localparam int unsigned TRAIL_W = 4;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_TRAIL = 3'd1;
  localparam logic [2:0] A_IEN   = 3'd2;
  localparam logic [2:0] A_STAT  = 3'd3;
  localparam logic [2:0] A_FSTAT = 3'd4;
  localparam logic [2:0] A_TXD   = 3'd5;
  localparam logic [2:0] A_RXD   = 3'd6;

  // status bit positions
  localparam int unsigned S_TX_AE  = 0;
  localparam int unsigned S_RX_AF  = 1;
  localparam int unsigned S_TX_UNF = 2;
  localparam int unsigned S_TX_OVF = 3;
  localparam int unsigned S_RX_UNF = 4;
  localparam int unsigned S_RX_OVF = 5;
  localparam int unsigned S_TRAIL  = 6;
endpackage

// File: rtl/fic_byte_fifo.sv
module fic_byte_fifo #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          push_i,
  input  logic [7:0]    din_i,
  input  logic          pop_i,
  output logic [7:0]    dout_o,
  output logic [CW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o,
  output logic          unf_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign ovf_o   = en_i & push_i & full_o;
  assign unf_o   = en_i & pop_i & empty_o;
  assign do_push = en_i & push_i & ~full_o;
  assign do_pop  = en_i & pop_i & ~empty_o;
  assign dout_o  = empty_o ? 8'h00 : mem_q[rd_q];
  assign level_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (!en_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CW'(DEPTH)); // R6
  AST_DISABLE_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> level_o == '0); // R2
  AST_OVF_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !pop_i |=> $stable(level_o)); // R6
  AST_UNF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> dout_o == 8'h00); // R7
endmodule

// File: rtl/fic_trail_timer.sv
module fic_trail_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cond_i,    // partial data waiting
  input  logic          arrive_i,  // byte arriving this cycle
  input  logic [CW-1:0] limit_i,
  output logic          fire_o
);
  logic [CW-1:0] idle_q;

  assign fire_o = cond_i & ~arrive_i & (idle_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  idle_q <= '0;
    else if (arrive_i || !cond_i) idle_q <= '0;
    else if (idle_q != limit_i)   idle_q <= idle_q + 1'b1;
  end

  AST_NO_FIRE_ON_ARRIVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arrive_i |-> !fire_o); // R9
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fic_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        tx_pop_i,
  output logic [7:0]  tx_data_o,
  input  logic        rx_push_i,
  input  logic [7:0]  rx_data_i,
  output logic        irq_o
);
  logic              rx_en_q, tx_en_q;
  logic [LVL_FW-1:0] rx_trig_q, tx_trig_q;
  logic [TRAIL_W-1:0] trail_q;
  logic [STAT_W-1:0] ien_q, stat_q, stat_set, w1c;
  logic              irq_q;

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [LVL_FW-1:0] tx_lvl, rx_lvl;
  logic tx_full, tx_empty, tx_ovf, tx_unf;
  logic rx_full, rx_empty, rx_ovf, rx_unf;
  logic [7:0] rx_dout;
  logic tx_push, rx_pop, trail_cond, trail_fire;

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata_i[31:23], reg_wdata_i[15:11], reg_wdata_i[3:2]};

  assign tx_push = reg_wr_i && (reg_addr_i == A_TXD);
  assign rx_pop  = reg_rd_i && (reg_addr_i == A_RXD);

  fic_byte_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .en_i(tx_en_q), .push_i(tx_push), .din_i(reg_wdata_i[7:0]),
    .pop_i(tx_pop_i), .dout_o(tx_data_o), .level_o(tx_cnt), .full_o(tx_full),
    .empty_o(tx_empty), .ovf_o(tx_ovf), .unf_o(tx_unf));

  fic_byte_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .en_i(rx_en_q), .push_i(rx_push_i), .din_i(rx_data_i),
    .pop_i(rx_pop), .dout_o(rx_dout), .level_o(rx_cnt), .full_o(rx_full),
    .empty_o(rx_empty), .ovf_o(rx_ovf), .unf_o(rx_unf));

  assign tx_lvl = LVL_FW'(tx_cnt);
  assign rx_lvl = LVL_FW'(rx_cnt);

  assign trail_cond = rx_en_q && (rx_lvl != '0) && (rx_lvl < rx_trig_q);

  fic_trail_timer #(.CW(TRAIL_W)) u_trail (
    .clk_i, .rst_ni, .cond_i(trail_cond), .arrive_i(rx_push_i),
    .limit_i(trail_q), .fire_o(trail_fire));

  always_comb begin
    stat_set           = '0;
    stat_set[S_TX_AE]  = tx_en_q && (tx_lvl <= tx_trig_q);
    stat_set[S_RX_AF]  = rx_en_q && (rx_lvl >= rx_trig_q);
    stat_set[S_TX_UNF] = tx_unf;
    stat_set[S_TX_OVF] = tx_ovf;
    stat_set[S_RX_UNF] = rx_unf;
    stat_set[S_RX_OVF] = rx_ovf;
    stat_set[S_TRAIL]  = trail_fire;
    w1c = (reg_wr_i && reg_addr_i == A_STAT) ? reg_wdata_i[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q   <= 1'b0;
      tx_en_q   <= 1'b0;
      rx_trig_q <= '0;
      tx_trig_q <= '0;
      trail_q   <= '0;
      ien_q     <= '0;
      stat_q    <= '0;
      irq_q     <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~w1c) | stat_set;
      irq_q  <= |(stat_q & ien_q);
      if (reg_wr_i) begin
        case (reg_addr_i)
          A_CTRL: begin
            rx_en_q   <= reg_wdata_i[0];
            tx_en_q   <= reg_wdata_i[1];
            rx_trig_q <= reg_wdata_i[10:4];
            tx_trig_q <= reg_wdata_i[22:16];
          end
          A_TRAIL: trail_q <= reg_wdata_i[TRAIL_W-1:0];
          A_IEN:   ien_q   <= reg_wdata_i[STAT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[0]     = rx_en_q;
        reg_rdata_o[1]     = tx_en_q;
        reg_rdata_o[10:4]  = rx_trig_q;
        reg_rdata_o[22:16] = tx_trig_q;
      end
      A_TRAIL: reg_rdata_o[TRAIL_W-1:0] = trail_q;
      A_IEN:   reg_rdata_o[STAT_W-1:0]  = ien_q;
      A_STAT:  reg_rdata_o[STAT_W-1:0]  = stat_q;
      A_FSTAT: begin
        reg_rdata_o[6:0]   = tx_lvl;
        reg_rdata_o[7]     = tx_full;
        reg_rdata_o[8]     = tx_empty;
        reg_rdata_o[22:16] = rx_lvl;
        reg_rdata_o[23]    = rx_full;
        reg_rdata_o[24]    = rx_empty;
      end
      A_RXD:   reg_rdata_o[7:0] = rx_dout;
      default: ;
    endcase
  end

  AST_TX_AE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_q && (tx_lvl <= tx_trig_q) |=> stat_q[S_TX_AE]); // R8
  AST_RX_AF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en_q && (rx_lvl >= rx_trig_q) |=> stat_q[S_RX_AF]); // R8
  AST_TRAIL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q[S_TRAIL]) |-> $past(rx_en_q && rx_lvl != '0 && rx_lvl < rx_trig_q)); // R9
  AST_W1C_ZERO_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i == A_STAT && ((reg_wdata_i[STAT_W-1:0] & stat_q) == '0)
    |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R10
  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(stat_q & ien_q))); // R11
endmodule

// File: tb/fifo_irq_ctrl_tb.sv
`timescale 1ns/1ps
module fifo_irq_ctrl_tb;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 0, reg_rd = 0, tx_pop = 0, rx_push = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [7:0]  rx_din = '0;
  logic [31:0] rdata;
  logic [7:0]  tx_data;
  logic        irq;

  always #2.5 clk = ~clk;

  fifo_irq_ctrl #(.DEPTH(D)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata),
    .tx_pop_i(tx_pop), .tx_data_o(tx_data), .rx_push_i(rx_push),
    .rx_data_i(rx_din), .irq_o(irq));

  int checks = 0, fails = 0, cyc = 0;
  bit started = 0;

  // behavioural reference model
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  bit [6:0] m_st = 0, m_en = 0;
  bit m_rx_en = 0, m_tx_en = 0, m_irq = 0;
  int m_rtrig = 0, m_ttrig = 0, m_trail = 0, m_idle = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rdata(input logic [2:0] a);
    logic [31:0] r = '0;
    case (a)
      3'd0: begin r[0] = m_rx_en; r[1] = m_tx_en; r[10:4] = 7'(m_rtrig); r[22:16] = 7'(m_ttrig); end
      3'd1: r[3:0] = 4'(m_trail);
      3'd2: r[6:0] = m_en;
      3'd3: r[6:0] = m_st;
      3'd4: begin
        r[6:0] = 7'(txq.size()); r[7] = (txq.size() == D); r[8] = (txq.size() == 0);
        r[22:16] = 7'(rxq.size()); r[23] = (rxq.size() == D); r[24] = (rxq.size() == 0);
      end
      3'd6: r[7:0] = (rxq.size() > 0) ? rxq[0] : 8'h00;
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin : model
    int ts, rs;
    bit tpush, rpop, cond;
    bit [6:0] set, w1c;
    if (rst_n) begin
      ts = txq.size(); rs = rxq.size();
      tpush = reg_wr && reg_addr == 3'd5;
      rpop  = reg_rd && reg_addr == 3'd6;
      set = '0;
      cond = m_rx_en && rs > 0 && rs < m_rtrig;
      if (m_tx_en) begin
        set[0] = (ts <= m_ttrig);
        if (tpush && ts == D) set[3] = 1;
        if (tx_pop && ts == 0) set[2] = 1;
      end
      if (m_rx_en) begin
        set[1] = (rs >= m_rtrig);
        if (rx_push && rs == D) set[5] = 1;
        if (rpop && rs == 0) set[4] = 1;
      end
      set[6] = cond && !rx_push && (m_idle == m_trail);
      if (rx_push || !cond) m_idle = 0;
      else if (m_idle != m_trail) m_idle++;
      m_irq = |(m_st & m_en);
      w1c = (reg_wr && reg_addr == 3'd3) ? reg_wdata[6:0] : 7'd0;
      m_st = (m_st & ~w1c) | set;
      if (!m_tx_en) txq.delete();
      else begin
        if (tx_pop && ts > 0) void'(txq.pop_front());
        if (tpush && ts < D) txq.push_back(reg_wdata[7:0]);
      end
      if (!m_rx_en) rxq.delete();
      else begin
        if (rpop && rs > 0) void'(rxq.pop_front());
        if (rx_push && rs < D) rxq.push_back(rx_din);
      end
      if (reg_wr) begin
        case (reg_addr)
          3'd0: begin m_rx_en = reg_wdata[0]; m_tx_en = reg_wdata[1];
                      m_rtrig = int'(reg_wdata[10:4]); m_ttrig = int'(reg_wdata[22:16]); end
          3'd1: m_trail = int'(reg_wdata[3:0]);
          3'd2: m_en = reg_wdata[6:0];
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && started) begin
      chk("R11 irq_o", {31'd0, irq}, {31'd0, m_irq});
      chk("R3 tx_data_o", {24'd0, tx_data}, {24'd0, (txq.size() > 0) ? txq[0] : 8'h00});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic drive(input bit wr, input bit rd, input logic [2:0] a, input logic [31:0] d,
                       input bit tp, input bit rp, input logic [7:0] din);
    @(posedge clk); #1;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    tx_pop = tp; rx_push = rp; rx_din = din;
  endtask

  task automatic nop(); drive(0, 0, 3'd7, 0, 0, 0, 0); endtask
  task automatic wr(input logic [2:0] a, input logic [31:0] d); drive(1, 0, a, d, 0, 0, 0); endtask

  task automatic rd_chk(input logic [2:0] a, input string tag);
    drive(0, 1, a, 0, 0, 0, 0);
    @(negedge clk);
    chk(tag, rdata, model_rdata(a));
  endtask

  localparam logic [31:0] CTRL_BOTH = 32'h3 | (32'd3 << 4) | (32'd1 << 16);

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    started = 1;
    rd_chk(3'd3, "R10 reset status");
    rd_chk(3'd4, "R5 R2 reset queue status");
    rd_chk(3'd0, "R1 reset control");
    wr(3'd0, CTRL_BOTH);
    wr(3'd1, 32'd3);
    rd_chk(3'd0, "R1 control readback");
    rd_chk(3'd1, "R9 trail readback");
    wr(3'd3, 32'h7f);
    for (int i = 0; i < 5; i++) wr(3'd5, 32'hA0 + i);   // fifth overruns
    rd_chk(3'd4, "R5 R6 tx full");
    rd_chk(3'd3, "R6 tx overrun");
    wr(3'd2, 32'h08);
    nop(); nop();
    wr(3'd3, 32'h08);
    wr(3'd2, 32'h04);
    for (int i = 0; i < 5; i++) drive(0, 0, 3'd7, 0, 1, 0, 0); // fifth underruns
    rd_chk(3'd3, "R7 tx underrun");
    rd_chk(3'd4, "R5 tx empty");
    // underrun with same-cycle push: push still lands
    wr(3'd3, 32'h7f);
    drive(1, 0, 3'd5, 32'h5C, 1, 0, 0);
    rd_chk(3'd4, "R7 push alongside empty pop");
    rd_chk(3'd3, "R7 underrun with push");
    drive(0, 0, 3'd7, 0, 1, 0, 0);
    // receive partial batch, trailing timer
    wr(3'd2, 32'h40);
    wr(3'd3, 32'h7f);
    drive(0, 0, 3'd7, 0, 0, 1, 8'h11);
    nop(); nop();
    drive(0, 0, 3'd7, 0, 0, 1, 8'h22);              // restarts timer
    nop(); nop();
    rd_chk(3'd3, "R9 trailing not yet");
    nop(); nop(); nop();
    rd_chk(3'd3, "R9 trailing fired");
    wr(3'd3, 32'h40);
    rd_chk(3'd3, "R10 set wins over clear");
    drive(0, 0, 3'd7, 0, 0, 1, 8'h33);
    drive(0, 0, 3'd7, 0, 0, 1, 8'h44);
    drive(0, 0, 3'd7, 0, 0, 1, 8'h55);              // overrun
    rd_chk(3'd4, "R5 R6 rx full");
    rd_chk(3'd3, "R8 R6 rx almost full and overrun");
    // overrun with same-cycle pop: pop still completes
    drive(0, 1, 3'd6, 0, 0, 1, 8'h66);
    @(negedge clk); chk("R4 R6 pop alongside full push", rdata, model_rdata(3'd6));
    for (int i = 0; i < 4; i++) rd_chk(3'd6, "R4 rx read");     // last underruns
    rd_chk(3'd3, "R7 rx underrun");
    wr(3'd3, 32'h0);
    rd_chk(3'd3, "R10 write zero keeps");
    wr(3'd2, 32'h7f);
    nop();
    wr(3'd2, 32'h00);
    nop(); nop();
    // disable transmit queue
    wr(3'd5, 32'h77);
    wr(3'd0, 32'h1 | (32'd3 << 4));
    nop();
    wr(3'd3, 32'h7f);
    wr(3'd5, 32'h78);
    drive(0, 0, 3'd7, 0, 1, 0, 0);
    rd_chk(3'd4, "R2 disabled tx flushed");
    rd_chk(3'd3, "R2 disabled tx no flags");
    wr(3'd0, 32'h0);
    drive(0, 0, 3'd7, 0, 0, 1, 8'h99);
    rd_chk(3'd4, "R2 disabled rx ignores push");
    wr(3'd0, 32'h3 | (32'd2 << 16));
    wr(3'd2, 32'h01);
    nop(); nop();
    for (int i = 0; i < 3; i++) wr(3'd5, 32'hC0 + i);
    nop(); nop();
    rd_chk(3'd3, "R8 tx almost empty");
    nop();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule